// File: doc/BRIEF.md
# Write-Spreading Victim Way Selector

This block picks the victim way for a fill or write into one set of an 8-way set-associative cache built from a memory technology that heats up under writes. The state is ranked by write order only. Each set holds one small position counter. The counter steps through a fixed, strided order of ways, so two writes to the same set in a row never land in neighbouring ways. The heat from back-to-back writes is therefore spread across the physical array and does not pile up on adjacent blocks.

The cache controller presents a set index on every cycle. The block answers at once with the way that the next write to that set will use. When the controller commits a write or fill, it raises the request strobe in that cycle. The block then flags the answer as valid, and on the next clock edge it advances that set's counter. Lookups that do not write leave the state alone. The cost is close to a FIFO policy: one 3-bit pointer per set and a small multiply-by-stride map.

Top module: `wsel_victim_top`

## Requirements
- R1: A set whose counter is at position p (0..7) offers way (3*p) mod 8 on `victim_way_o`. The order of offered ways is therefore 0,3,6,1,4,7,2,5, and it wraps back to 0.
- R2: Any two successive victims handed out for the same set differ in way number by at least 3 in absolute value, including the wrap from the eighth write back to the first.
- R3: Within each run of 8 consecutive committed writes to one set, starting from reset, every way 0..7 is used exactly once.
- R4: A request (`req_i` high while `rst_n` is high at a rising clock edge) advances the counter of set `req_set_i` by exactly one position, modulo 8.
- R5: A request to one set leaves the counters of all other sets unchanged.
- R6: `victim_valid_o` equals `req_i` while out of reset. `victim_way_o` is a combinational function of `req_set_i` and the stored counters, so the answer appears in the same cycle as the request.
- R7: Reset, active low and asynchronous, returns every set's counter to position 0, so the first victim of every set is way 0.
- R8: While `rst_n` is low, `victim_valid_o` is low and a request has no effect on any counter.
- R9: With `req_i` low, `victim_way_o` still shows the pending victim of `req_set_i`, and no counter changes. A non-writing lookup therefore never disturbs the replacement order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Write/fill commit strobe for the presented set |
| req_set_i | input | SET_W (4) | Set index being looked up or written |
| victim_way_o | output | WAY_W (3) | Way that the next write to the presented set will use |
| victim_valid_o | output | 1 | High when a committed request is being answered |

## Verification
A corrupted counter shows at the ports on the very next lookup of that set, because the offered way is a direct function of the stored position. A counter that skips, sticks or jumps breaks either the expected strided order or the spacing of at least three on the next write. A counter that fails to wrap or repeats a position shows up no later than the end of that set's current run of eight writes, when the per-window coverage of all ways no longer holds. A request that leaks into the wrong set, or that takes effect during reset, is seen as soon as the bench next peeks at the victim sequence of a set it did not write.

// File: rtl/wsel_pkg.sv
package wsel_pkg;

    // Absolute distance between two way numbers.
    function automatic int way_gap(input int a, input int b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/wsel_seq_map.sv
// Maps a sequence position to a physical way: way = (pos * STRIDE) mod WAYS.
// WAYS must be a power of two and STRIDE odd, so the map is a permutation.
module wsel_seq_map #(
    parameter int WAYS   = 8,
    parameter int STRIDE = 3,
    localparam int W     = $clog2(WAYS),
    localparam int PW    = W + 8
) (
    input  logic [W-1:0] pos_i,
    output logic [W-1:0] way_o
);
    logic [PW-1:0] prod;

    always_comb begin
        prod  = {8'd0, pos_i} * PW'(STRIDE);
        way_o = prod[W-1:0];
    end

endmodule

// File: rtl/wsel_ptr_bank.sv
// Per-set position counters. Two-process style.
module wsel_ptr_bank #(
    parameter int SETS  = 16,
    parameter int POS_W = 3,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [SET_W-1:0] adv_set_i,
    input  logic [SET_W-1:0] rd_set_i,
    output logic [POS_W-1:0] rd_pos_o
);
    typedef struct packed {
        logic [SETS-1:0][POS_W-1:0] ptr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.ptr[adv_set_i] = st_q.ptr[adv_set_i] + POS_W'(1);
        end
        rd_pos_o = st_q.ptr[rd_set_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < SETS; i++) begin : g_set_chk
        // R4: a commit to this set moves its counter one step forward
        a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
            (adv_i && adv_set_i == SET_W'(i)) |=>
                st_q.ptr[i] == POS_W'($past(st_q.ptr[i]) + POS_W'(1)));
        // R5: no commit to this set keeps its counter still
        a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(adv_i && adv_set_i == SET_W'(i)) |=> $stable(st_q.ptr[i]));
    end

endmodule

// File: rtl/wsel_victim_top.sv
module wsel_victim_top #(
    parameter int WAYS   = 8,
    parameter int SETS   = 16,
    parameter int STRIDE = 3,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [SET_W-1:0] req_set_i,
    output logic [WAY_W-1:0] victim_way_o,
    output logic             victim_valid_o
);
    import wsel_pkg::*;

    logic             commit;
    logic [WAY_W-1:0] cur_pos;

    always_comb begin
        commit         = req_i & rst_n;
        victim_valid_o = commit;
    end

    wsel_ptr_bank #(
        .SETS  (SETS),
        .POS_W (WAY_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (commit),
        .adv_set_i (req_set_i),
        .rd_set_i  (req_set_i),
        .rd_pos_o  (cur_pos)
    );

    wsel_seq_map #(
        .WAYS   (WAYS),
        .STRIDE (STRIDE)
    ) u_map (
        .pos_i (cur_pos),
        .way_o (victim_way_o)
    );

    // R2: back-to-back commits to one set land at least three ways apart
    a_r2_far_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid_o && $past(victim_valid_o) && req_set_i == $past(req_set_i))
            |-> way_gap(int'(victim_way_o), int'($past(victim_way_o))) >= 3);

    // R8: nothing is answered while reset is held
    a_r8_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> !victim_valid_o);

    // R9: a cycle without a commit leaves the offered way of that set unchanged
    a_r9_peek_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && $stable(req_set_i)) |=> ($stable(req_set_i) -> $stable(victim_way_o)));

endmodule

// File: tb/wsel_victim_top_tb.sv
`timescale 1ns/1ps
module wsel_victim_top_tb;
    localparam int SETS = 16;
    localparam int SEQ [8] = '{0, 3, 6, 1, 4, 7, 2, 5};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic [3:0] req_set_i = '0;
    logic [2:0] victim_way_o;
    logic       victim_valid_o;

    int checks = 0;
    int errors = 0;

    int pos       [SETS];
    int last_way  [SETS];
    bit have_last [SETS];
    int wcnt      [SETS];
    bit [7:0] seen[SETS];

    always #2.5 clk = ~clk;

    wsel_victim_top u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req_i),
        .req_set_i      (req_set_i),
        .victim_way_o   (victim_way_o),
        .victim_valid_o (victim_valid_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            pos[s] = 0; have_last[s] = 0; wcnt[s] = 0; seen[s] = '0;
        end
    endtask

    // Peek without committing; checks the offered way (R9, R1).
    task automatic peek(input int s, input string req);
        @(negedge clk);
        req_i = 1'b0; req_set_i = 4'(s);
        #1;
        chk(req, int'(victim_way_o), SEQ[pos[s]]);
        chk({req, " valid low"}, int'(victim_valid_o), 0);
    endtask

    // Commit one write to set s and check everything observable.
    task automatic wr(input int s);
        int w;
        @(negedge clk);
        req_i = 1'b1; req_set_i = 4'(s);
        #1;
        w = int'(victim_way_o);
        chk("R6 valid with request", int'(victim_valid_o), 1);
        chk("R1 strided way", w, SEQ[pos[s]]);
        if (have_last[s]) begin
            checks++;
            if ((w > last_way[s] ? w - last_way[s] : last_way[s] - w) < 3) begin
                errors++;
                $display("FAIL R2 spacing set %0d: actual %0d after %0d expected gap>=3",
                         s, w, last_way[s]);
            end
        end
        last_way[s] = w; have_last[s] = 1;
        seen[s][w] = 1'b1;
        wcnt[s]++;
        if (wcnt[s] % 8 == 0) begin
            chk("R3 all ways per 8 writes", int'(seen[s]), 8'hFF);
            seen[s] = '0;
        end
        @(posedge clk);
        pos[s] = (pos[s] + 1) % 8;
        #1;
        req_i = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0; req_i = 1'b1; req_set_i = 4'd5;
        #1;
        chk("R8 valid low in reset", int'(victim_valid_o), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        req_i = 1'b0; rst_n = 1'b1;
        model_reset();
        for (int s = 0; s < SETS; s++) peek(s, "R7 R8 way 0 after reset");
    endtask

    task automatic t_one_set_full_cycle();
        for (int k = 0; k < 17; k++) wr(3);
        peek(3, "R1 wrap position");
    endtask

    task automatic t_isolation();
        for (int k = 0; k < 5; k++) wr(9);
        for (int s = 0; s < SETS; s++) peek(s, "R5 other sets untouched");
    endtask

    task automatic t_peek_stable();
        for (int k = 0; k < 4; k++) peek(9, "R9 lookup does not advance");
        wr(9);
        peek(9, "R4 advanced by one");
    endtask

    task automatic t_random_sets();
        for (int k = 0; k < 2000; k++) wr(int'($urandom_range(SETS - 1, 0)));
        for (int s = 0; s < SETS; s++) peek(s, "R4 R1 position after random");
    endtask

    task automatic t_reset_midway();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        req_i = 1'b1; req_set_i = 4'd2;
        #1;
        chk("R8 no valid in reset", int'(victim_valid_o), 0);
        @(negedge clk);
        req_i = 1'b0; rst_n = 1'b1;
        model_reset();
        peek(2, "R7 R8 set 2 back at way 0");
        wr(2); wr(2);
        peek(2, "R1 third way after reset");
    endtask

    initial begin
        void'($urandom(32'd7));
        model_reset();
        t_reset_state();
        t_one_set_full_cycle();
        t_isolation();
        t_peek_stable();
        t_random_sets();
        t_reset_midway();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule